// File: doc/BRIEF.md
# Operand-Freezing Registered Magnitude Comparator

This block registers two unsigned operands and, one clock later, reports whether the first is strictly greater than the second. The operand registers are split: a narrow group holding the top bit pair (or top two bit pairs) is written on every clock, while the wide group holding the remaining lower bits is written only when the top bits of the incoming operands leave the answer open.

A small predictor looks at the top bits of the operands arriving at the register inputs. When those bits already settle the comparison, the lower registers keep their previous contents, so the comparator behind them sees only the top bits toggle. The result is still exact, because the bits that decide it are always fresh. A parameter picks whether the predictor inspects one or two bit pairs: two pairs freeze the lower bits more often for a slightly larger predictor. A one-bit flag tells the surrounding logic, and the bench, that the most recent capture kept the lower bits frozen.

Top module: `lpc_mag_cmp`

## Requirements
- R1: While `rst` is high at a rising edge, both `a_gt_b` and `lo_frozen` read 0 after that edge, and all operand registers clear to 0.
- R2: Operands sampled at rising edge k give `a_gt_b` = (`op_a` > `op_b`, unsigned) after edge k+1, whatever the lower operand bits were.
- R3: With one pair (`PRED_PAIRS`=1), when bit WIDTH-1 of `op_a` and `op_b` differ at a capture edge (1/0 means greater, 0/1 means less), the lower registers keep their old value and `lo_frozen` reads 1 after that edge.
- R4: When every inspected top bit pair is equal at a capture edge, all operand bits are loaded and `lo_frozen` reads 0 after that edge.
- R5: With two pairs (`PRED_PAIRS`=2), the lower registers are also frozen when bits WIDTH-1 match and bits WIDTH-2 differ; bits WIDTH-1 and WIDTH-2 are always loaded.
- R6: A freeze never corrupts the result: a sequence where lower bits change only during frozen captures still yields the exact comparison for each capture.
- R7: `PRED_PAIRS` outside 1..2, or `WIDTH` not larger than `PRED_PAIRS`, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| a_gt_b | output | 1 | Registered result of op_a > op_b |
| lo_frozen | output | 1 | 1 when the last capture kept the lower operand bits frozen |

## Verification
Both predictor widths run side by side on the same stream. Directed pairs with differing MSBs in both directions separate the greater and less predictions, pairs with equal MSBs but differing next bits separate the one-pair and two-pair variants, and pairs equal in the top bits force a full load and a decision in the lower bits. A sequence that changes the lower bits only while they are frozen, then releases them, shows whether stale lower bits ever leak into the result, and a long random stream checks the freeze ratio and the result in general.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
   // number of top bit pairs the predictor may inspect
   localparam int unsigned LPC_MAX_PAIRS = 2;

   // true when a is strictly greater than b on a single bit
   function automatic logic bit_gt(input logic a, input logic b);
      return a & ~b;
   endfunction
endpackage

// File: rtl/lpc_predictor.sv
module lpc_predictor #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned PAIRS = 1
) (
   input  logic [WIDTH-1:0] nxt_a,
   input  logic [WIDTH-1:0] nxt_b,
   output logic             hint_gt,
   output logic             hint_lt
);
   import lpc_pkg::*;

   localparam int unsigned TOP = WIDTH - 1;

   generate
      if (PAIRS == 1) begin : g_one
         always_comb begin
            hint_gt = bit_gt(nxt_a[TOP], nxt_b[TOP]);
            hint_lt = bit_gt(nxt_b[TOP], nxt_a[TOP]);
         end
      end else begin : g_two
         logic top_eq;
         always_comb begin
            top_eq  = ~(nxt_a[TOP] ^ nxt_b[TOP]);
            hint_gt = bit_gt(nxt_a[TOP], nxt_b[TOP])
                    | (top_eq & bit_gt(nxt_a[TOP-1], nxt_b[TOP-1]));
            hint_lt = bit_gt(nxt_b[TOP], nxt_a[TOP])
                    | (top_eq & bit_gt(nxt_b[TOP-1], nxt_a[TOP-1]));
         end
      end
   endgenerate
endmodule

// File: rtl/lpc_split_reg.sv
module lpc_split_reg #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned HI_LEN = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lo_load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned LO_LEN = WIDTH - HI_LEN;

   logic [HI_LEN-1:0] hi_q;
   logic [LO_LEN-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (rst) hi_q <= '0;
      else     hi_q <= d[WIDTH-1 -: HI_LEN];
   end

   always_ff @(posedge clk) begin
      if (rst)          lo_q <= '0;
      else if (lo_load) lo_q <= d[LO_LEN-1:0];
   end

   assign q = {hi_q, lo_q};
endmodule

// File: rtl/lpc_core.sv
module lpc_core #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] reg_a,
   input  logic [WIDTH-1:0] reg_b,
   output logic             gt_q
);
   always_ff @(posedge clk) begin
      if (rst) gt_q <= 1'b0;
      else     gt_q <= (reg_a > reg_b);
   end
endmodule

// File: rtl/lpc_mag_cmp.sv
module lpc_mag_cmp #(
   parameter int unsigned WIDTH      = 16,
   parameter int unsigned PRED_PAIRS = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic             a_gt_b,
   output logic             lo_frozen
);
   import lpc_pkg::*;

   // R7: parameter legality
   generate
      if (PRED_PAIRS < 1 || PRED_PAIRS > LPC_MAX_PAIRS) begin : g_bad_pairs
         $error("lpc_mag_cmp: PRED_PAIRS must be 1 or 2");
      end
      if (WIDTH <= PRED_PAIRS) begin : g_bad_width
         $error("lpc_mag_cmp: WIDTH must exceed PRED_PAIRS");
      end
   endgenerate

   logic             hint_gt;
   logic             hint_lt;
   logic             lo_load;
   logic [WIDTH-1:0] reg_a;
   logic [WIDTH-1:0] reg_b;

   lpc_predictor #(.WIDTH(WIDTH), .PAIRS(PRED_PAIRS)) u_pred (
      .nxt_a   (op_a),
      .nxt_b   (op_b),
      .hint_gt (hint_gt),
      .hint_lt (hint_lt)
   );

   assign lo_load = ~(hint_gt | hint_lt);

   lpc_split_reg #(.WIDTH(WIDTH), .HI_LEN(PRED_PAIRS)) u_reg_a (
      .clk     (clk),
      .rst     (rst),
      .lo_load (lo_load),
      .d       (op_a),
      .q       (reg_a)
   );

   lpc_split_reg #(.WIDTH(WIDTH), .HI_LEN(PRED_PAIRS)) u_reg_b (
      .clk     (clk),
      .rst     (rst),
      .lo_load (lo_load),
      .d       (op_b),
      .q       (reg_b)
   );

   lpc_core #(.WIDTH(WIDTH)) u_core (
      .clk   (clk),
      .rst   (rst),
      .reg_a (reg_a),
      .reg_b (reg_b),
      .gt_q  (a_gt_b)
   );

   always_ff @(posedge clk) begin
      if (rst) lo_frozen <= 1'b0;
      else     lo_frozen <= ~lo_load;
   end
endmodule

// File: rtl/lpc_chk.sv
module lpc_chk #(
   parameter int unsigned W     = 16,
   parameter int unsigned PAIRS = 1
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic         a_gt_b,
   input logic         lo_frozen
);
   logic [1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst)               run_cnt <= 2'd0;
      else if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!a_gt_b && !lo_frozen));

   // R3
   msb_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (op_a[W-1] != op_b[W-1]) |=> lo_frozen);

   // R4
   top_match_load_chk: assert property (@(posedge clk) disable iff (rst)
      (op_a[W-1 -: PAIRS] == op_b[W-1 -: PAIRS]) |=> !lo_frozen);

   // R2
   result_chk: assert property (@(posedge clk) disable iff (rst)
      (run_cnt == 2'd2) |-> (a_gt_b == ($past(op_a, 2) > $past(op_b, 2))));

   generate
      if (PAIRS == 2) begin : g_pair2
         // R5
         second_pair_freeze_chk: assert property (@(posedge clk) disable iff (rst)
            (op_a[W-1] == op_b[W-1] && op_a[W-2] != op_b[W-2]) |=> lo_frozen);
      end
   endgenerate
endmodule

bind lpc_mag_cmp lpc_chk #(.W(WIDTH), .PAIRS(PRED_PAIRS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .op_a      (op_a),
   .op_b      (op_b),
   .a_gt_b    (a_gt_b),
   .lo_frozen (lo_frozen)
);

// File: tb/lpc_mag_cmp_bench.sv
module lpc_mag_cmp_bench;
   localparam int unsigned W = 16;

   typedef struct {
      logic  gt;
      logic  frz1;
      logic  frz2;
      string tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         gt1, frz1, gt2, frz2;

   int  checks   = 0;
   int  failures = 0;
   int  held1    = 0;
   int  held2    = 0;
   bit  mon_on   = 1'b0;
   bit  finished = 1'b0;
   exp_t q[$];

   always #4 clk = ~clk;

   lpc_mag_cmp #(.WIDTH(W), .PRED_PAIRS(1)) u_lpc_mag_cmp (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
      .a_gt_b(gt1), .lo_frozen(frz1));

   lpc_mag_cmp #(.WIDTH(W), .PRED_PAIRS(2)) u_lpc_mag_cmp_p2 (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
      .a_gt_b(gt2), .lo_frozen(frz2));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   // driver: apply one operand pair and push its expected outcome
   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      exp_t e;
      @(negedge clk);
      op_a   = a;
      op_b   = b;
      e.gt   = (a > b);
      e.frz1 = (a[W-1] != b[W-1]);
      e.frz2 = (a[W-1] != b[W-1]) || (a[W-2] != b[W-2]);
      e.tag  = tag;
      q.push_back(e);
   endtask

   // monitor: freeze flag checked after the capture edge, result one edge later
   initial begin
      exp_t stage;
      bit   stage_ok = 1'b0;
      forever begin
         @(posedge clk);
         #2;
         if (mon_on) begin
            if (stage_ok) begin
               check({"R2 ", stage.tag, " p1"}, gt1, stage.gt);
               check({"R2 ", stage.tag, " p2"}, gt2, stage.gt);
            end
            if (q.size() > 0) begin
               stage    = q.pop_front();
               stage_ok = 1'b1;
               check({"R3/R4 ", stage.tag, " p1 frozen"}, frz1, stage.frz1);
               check({"R5 ", stage.tag, " p2 frozen"}, frz2, stage.frz2);
               if (frz1) held1++;
               if (frz2) held2++;
            end else begin
               stage_ok = 1'b0;
            end
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset with busy inputs
      op_a = 16'hFFFF;
      op_b = 16'h0001;
      repeat (3) @(posedge clk);
      #2;
      check("R1 result p1", gt1, 1'b0);
      check("R1 frozen p1", frz1, 1'b0);
      check("R1 result p2", gt2, 1'b0);
      check("R1 frozen p2", frz2, 1'b0);
      @(negedge clk);
      rst    = 1'b0;
      mon_on = 1'b1;

      // R3: MSB decides, both directions
      drive(16'h8000, 16'h7FFF, "msb gt");
      drive(16'h0123, 16'hF000, "msb lt");
      // R4: top bits equal, lower bits decide
      drive(16'h1235, 16'h1234, "low gt");
      drive(16'h1234, 16'h1234, "equal");
      drive(16'hC000, 16'hC001, "low lt");
      // R5: MSBs equal, next bit differs
      drive(16'h4000, 16'h3FFF, "bit14 gt");
      drive(16'h2FFF, 16'h4000, "bit14 lt");

      // R6: lower bits change only while frozen, then release
      drive(16'h0005, 16'h0003, "R6 load");
      drive(16'h8002, 16'h7FFF, "R6 frozen gt");
      drive(16'h0A01, 16'h8F00, "R6 frozen lt");
      drive(16'h0001, 16'h0002, "R6 release");
      drive(16'h0004, 16'h0004, "R6 equal");

      for (int i = 0; i < 2000; i++) begin
         drive(W'($urandom), W'($urandom), "random");
      end
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      mon_on = 1'b0;

      // frozen share under random stimulus (roughly 1/2 and 3/4)
      checks++;
      if (held1 < 800 || held1 > 1250 || held2 < 1300 || held2 > 1750) begin
         failures++;
         $display("FAIL R5 freeze ratio actual=%0d/%0d expected=~1000/~1500",
                  held1, held2);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule